// File: doc/BRIEF.md
# Shader Microprogram Store and Sequencer

This block holds a small shader microprogram and steps through it. Each instruction is 128 bits wide and is loaded as four 32-bit words through a single command port. A slot-select command sets where the next instruction lands. Each complete instruction advances that slot by one, so a whole program streams in after a single slot-select. The entry point is given by a separate run command. Subroutines can therefore be placed anywhere, including below the main routine.

While running, the sequencer presents the current program counter and the 128-bit instruction stored there. It follows unconditional and conditional jumps, calls and returns, and flags the instruction that ends the program. The condition result comes from outside, from whatever evaluates the instruction's condition test. Loops are built from a counter held in a temporary register plus a conditional jump back. Return addresses live in a small stack. A call into a full stack, or a return from an empty one, stops execution and raises a sticky fault. Decoding of the arithmetic operations is left to other logic.

Top module: `shprog_seq`

## Requirements
- R1: An instruction is committed only when its fourth word arrives. The first word written forms bits 31:0, the second bits 63:32, the third bits 95:64 and the fourth bits 127:96, and the committed value appears on `instr_o` whenever `pc_o` selects that slot.
- R2: Command 0 (slot select) loads `upload_slot_o` from `cmd_data[SLOT_W-1:0]` and restarts the word count. Words of a partly written instruction are discarded and the target slot keeps its previous contents.
- R3: Each committed instruction increments `upload_slot_o` by one, wrapping from 2^SLOT_W-1 to 0.
- R4: Command 2 (run) sets `run_o` and loads `pc_o` from `cmd_data[SLOT_W-1:0]` on the next clock. It also clears `err_o` and empties the return stack, and it takes effect even while a program is running.
- R5: A running instruction with flow code 00 (word 0 bits 1:0), or a flow instruction whose condition fails, moves `pc_o` to `pc_o`+1 modulo 2^SLOT_W.
- R6: Flow code 01 jumps to the target held in bits [SLOT_W-1:0] of word 2 (instruction bits 64 upward); higher bits of word 2 are ignored. When word 0 bit 2 is set the flow action happens only if `cond_pass` is 1, otherwise it always happens. A conditional jump back onto itself repeats until `cond_pass` falls.
- R7: Flow code 10 (call) pushes `pc_o`+1 and jumps to the target. Flow code 11 (return) pops the most recent address into `pc_o`. Nesting is last-in first-out.
- R8: While an instruction with instruction bit 96 (word 3 bit 0) set is current and running, `done_o` is 1 and its flow code is ignored. On the next clock `run_o` falls and `pc_o` holds.
- R9: A taken call with RET_DEPTH entries already stacked, or a taken return with an empty stack, sets `err_o`, clears `run_o` and leaves `pc_o` unchanged. A return whose condition fails does not fault.
- R10: After reset `run_o`, `err_o` and `done_o` are 0, and `pc_o` and `upload_slot_o` are 0.
- R11: Command 3 has no effect on the upload slot, the word count, or execution state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 slot select, 1 instruction word, 2 run from entry, 3 none |
| cmd_data | input | 32 | Command payload |
| cond_pass | input | 1 | Condition test result for the current instruction |
| run_o | output | 1 | Sequencer is executing |
| pc_o | output | SLOT_W | Program counter |
| instr_o | output | 128 | Instruction at `pc_o` |
| done_o | output | 1 | Current instruction ends the program |
| err_o | output | 1 | Sticky return-stack fault |
| upload_slot_o | output | SLOT_W | Slot receiving the next instruction |

## Verification
The bench fills every slot of a 64-slot store in one stream, which exposes a wrong word order or a missed increment as a mismatch on some slot, and a missing wrap as a lost write to slot 0. It abandons an instruction half way and re-targets the upload; a design that committed early or kept the word count would corrupt the old slot or misalign the new one. It sweeps every combination of the conditional bit and the condition input on jumps, including a self loop that must exit when the condition falls. It drives nested calls down to the fifth level and returns from an empty stack, so a design that mis-indexed the stack, faulted on a return whose condition fails, or kept stale entries across a run command returns to a wrong slot or misses the fault.

// File: rtl/shprog_pkg.sv
package shprog_pkg;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int INSTR_W = WORD_W * WORDS;
  localparam int END_BIT = 3 * WORD_W;   // word 3, bit 0
  localparam int TGT_LSB = 2 * WORD_W;   // target shares word 2
  localparam int COND_BIT = 2;           // word 0, bit 2

  typedef enum logic [1:0] {
    CMD_SET_SLOT = 2'd0,
    CMD_WORD     = 2'd1,
    CMD_RUN      = 2'd2,
    CMD_IDLE     = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_JUMP = 2'd1,
    FL_CALL = 2'd2,
    FL_RET  = 2'd3
  } flow_e;

  function automatic flow_e flow_of(input logic [INSTR_W-1:0] ins);
    return flow_e'(ins[1:0]);
  endfunction

  function automatic logic cond_of(input logic [INSTR_W-1:0] ins);
    return ins[COND_BIT];
  endfunction

  function automatic logic end_of(input logic [INSTR_W-1:0] ins);
    return ins[END_BIT];
  endfunction

  // a flow action happens when unconditional, or when the test passes
  function automatic logic take_flow(input logic conditional, input logic pass);
    return !conditional || pass;
  endfunction
endpackage

// File: rtl/shprog_loader.sv
module shprog_loader
  import shprog_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_slot,
  input  logic                word_wr,
  input  logic [WORD_W-1:0]   data,
  output logic                wr_en,
  output logic [SLOT_W-1:0]   wr_slot,
  output logic [INSTR_W-1:0]  wr_data,
  output logic [SLOT_W-1:0]   slot_o
);
  localparam int CNT_W = $clog2(WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0]              wcnt;
  logic [SLOT_W-1:0]             slot;
  logic [WORDS-2:0][WORD_W-1:0]  held;

  for (genvar g = 0; g < WORDS - 1; g++) begin : g_lane
    logic [WORD_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (word_wr && wcnt == CNT_W'(g)) lane_q <= data;
    end
    assign held[g] = lane_q;
  end

  assign wr_en   = word_wr && (wcnt == LAST);
  assign wr_slot = slot;
  assign wr_data = {data, held};
  assign slot_o  = slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      slot <= '0;
    end else if (set_slot) begin
      wcnt <= '0;
      slot <= data[SLOT_W-1:0];
    end else if (word_wr) begin
      wcnt <= wcnt + 1'b1;
      if (wcnt == LAST) slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/shprog_store.sv
module shprog_store
  import shprog_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [INSTR_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0]   rd_slot,
  output logic [INSTR_W-1:0]  rd_data
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [INSTR_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  assign rd_data = mem[rd_slot];
endmodule

// File: rtl/shprog_retstack.sv
module shprog_retstack #(
  parameter int SLOT_W = 6,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [SLOT_W-1:0] push_val,
  output logic [SLOT_W-1:0] top_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SP_W-1:0]   sp;
  logic [SLOT_W-1:0] ent [DEPTH];

  assign full_o  = (sp == SP_W'(DEPTH));
  assign empty_o = (sp == '0);
  assign top_o   = ent[IDX_W'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (push && !full_o) ent[sp[IDX_W-1:0]] <= push_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sp <= '0;
    else if (clr)               sp <= '0;
    else if (push && !full_o)   sp <= sp + 1'b1;
    else if (pop && !empty_o)   sp <= sp - 1'b1;
  end
endmodule

// File: rtl/shprog_seq.sv
module shprog_seq
  import shprog_pkg::*;
#(
  parameter int SLOT_W    = 6,
  parameter int RET_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [31:0]         cmd_data,
  input  logic                cond_pass,
  output logic                run_o,
  output logic [SLOT_W-1:0]   pc_o,
  output logic [127:0]        instr_o,
  output logic                done_o,
  output logic                err_o,
  output logic [SLOT_W-1:0]   upload_slot_o
);
  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    return s + 1'b1;
  endfunction

  cmd_e op;
  assign op = cmd_e'(cmd_op);

  logic set_slot_w, word_w, start_w;
  assign set_slot_w = cmd_valid && (op == CMD_SET_SLOT);
  assign word_w     = cmd_valid && (op == CMD_WORD);
  assign start_w    = cmd_valid && (op == CMD_RUN);

  // upload path
  logic               commit_w;
  logic [SLOT_W-1:0]  wr_slot;
  logic [INSTR_W-1:0] wr_data;

  shprog_loader #(.SLOT_W(SLOT_W)) loader_i (
    .clk(clk), .rst_n(rst_n), .set_slot(set_slot_w), .word_wr(word_w),
    .data(cmd_data), .wr_en(commit_w), .wr_slot(wr_slot),
    .wr_data(wr_data), .slot_o(upload_slot_o)
  );

  logic [SLOT_W-1:0]  pc;
  logic [INSTR_W-1:0] cur;

  shprog_store #(.SLOT_W(SLOT_W)) store_i (
    .clk(clk), .wr_en(commit_w), .wr_slot(wr_slot), .wr_data(wr_data),
    .rd_slot(pc), .rd_data(cur)
  );

  // decode of the sequencing fields
  logic  run, err;
  flow_e fl;
  logic  end_w, active_w, taken_w;
  logic  jump_w, call_w, ret_w;
  logic  push_w, pop_w, ovf_w, unf_w;
  logic  full_w, empty_w, plain_w;
  logic [SLOT_W-1:0] tgt, top, pc_next;

  assign fl       = flow_of(cur);
  assign end_w    = end_of(cur);
  assign tgt      = cur[TGT_LSB +: SLOT_W];
  assign active_w = run && !start_w && !end_w;
  assign taken_w  = active_w && take_flow(cond_of(cur), cond_pass);
  assign jump_w   = taken_w && (fl == FL_JUMP);
  assign call_w   = taken_w && (fl == FL_CALL);
  assign ret_w    = taken_w && (fl == FL_RET);
  assign push_w   = call_w && !full_w;
  assign ovf_w    = call_w && full_w;
  assign pop_w    = ret_w && !empty_w;
  assign unf_w    = ret_w && empty_w;
  assign plain_w  = active_w && !jump_w && !call_w && !ret_w;

  shprog_retstack #(.SLOT_W(SLOT_W), .DEPTH(RET_DEPTH)) stack_i (
    .clk(clk), .rst_n(rst_n), .clr(start_w), .push(push_w), .pop(pop_w),
    .push_val(slot_inc(pc)), .top_o(top), .full_o(full_w), .empty_o(empty_w)
  );

  always_comb begin
    if (pop_w)                 pc_next = top;
    else if (jump_w || push_w) pc_next = tgt;
    else                       pc_next = slot_inc(pc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      err <= 1'b0;
      pc  <= '0;
    end else if (start_w) begin
      run <= 1'b1;
      err <= 1'b0;
      pc  <= cmd_data[SLOT_W-1:0];
    end else if (run) begin
      if (end_w) begin
        run <= 1'b0;
      end else if (ovf_w || unf_w) begin
        run <= 1'b0;
        err <= 1'b1;
      end else begin
        pc  <= pc_next;
      end
    end
  end

  assign run_o   = run;
  assign err_o   = err;
  assign pc_o    = pc;
  assign instr_o = cur;
  assign done_o  = run && end_w;
endmodule

// File: rtl/shprog_seq_chk.sv
module shprog_seq_chk #(
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_o,
  input logic              err_o,
  input logic              done_o,
  input logic [SLOT_W-1:0] pc_o,
  input logic [SLOT_W-1:0] upload_slot_o,
  input logic [SLOT_W-1:0] entry,
  input logic              start_w,
  input logic              commit_w,
  input logic              plain_w,
  input logic              end_w,
  input logic              ovf_w,
  input logic              unf_w
);
  assert_commit_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> upload_slot_o == SLOT_W'($past(upload_slot_o) + 1'b1));

  assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (run_o && !err_o && pc_o == $past(entry)));

  assert_plain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    plain_w |=> pc_o == SLOT_W'($past(pc_o) + 1'b1));

  assert_end_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && end_w && !start_w) |=> (!run_o && $stable(pc_o)));

  assert_done_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> run_o);

  assert_fault_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_w || unf_w) |=> (err_o && !run_o && $stable(pc_o)));
endmodule

bind shprog_seq shprog_seq_chk #(.SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_o(run_o), .err_o(err_o), .done_o(done_o),
  .pc_o(pc_o), .upload_slot_o(upload_slot_o), .entry(cmd_data[SLOT_W-1:0]),
  .start_w(start_w), .commit_w(commit_w), .plain_w(plain_w), .end_w(end_w),
  .ovf_w(ovf_w), .unf_w(unf_w)
);

// File: tb/shprog_seq_tb_top.sv
`timescale 1ns/1ps
module shprog_seq_tb_top;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd3;
  logic [31:0]   cmd_data = '0;
  logic          cond_pass = 1'b0;
  logic          run_o, done_o, err_o;
  logic [SW-1:0] pc_o, upload_slot_o;
  logic [127:0]  instr_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  shprog_seq #(.SLOT_W(SW), .RET_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cond_pass(cond_pass), .run_o(run_o), .pc_o(pc_o),
    .instr_o(instr_o), .done_o(done_o), .err_o(err_o),
    .upload_slot_o(upload_slot_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3; cmd_data = '0;
  endtask

  task automatic put(input logic [31:0] w0, input logic [31:0] w1,
                     input logic [31:0] w2, input logic [31:0] w3);
    cmd(2'd1, w0); cmd(2'd1, w1); cmd(2'd1, w2); cmd(2'd1, w3);
  endtask

  task automatic load_at(input int s, input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input logic [31:0] w3);
    cmd(2'd0, 32'(s));
    put(w0, w1, w2, w3);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [127:0] sig(input int i);
    logic [31:0] w0, w1, w2, w3;
    w0 = 32'(i) << 8;
    w1 = 32'hA500_0000 | 32'(i);
    w2 = 32'(i) << 16;
    w3 = (32'(i) << 4) | ((i == 63) ? 32'd1 : 32'd0);
    return {w3, w2, w1, w0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(run_o == 0 && err_o == 0 && done_o == 0, "R10", "flags", {run_o, err_o, done_o}, 0);
    check(pc_o == 0, "R10", "pc", pc_o, 0);
    check(upload_slot_o == 0, "R10", "upload slot", upload_slot_o, 0);

    // R1 R3: stream all 64 slots, check increment and wrap
    cmd(2'd0, 32'd0);
    for (int i = 0; i < 64; i++) begin
      a = sig(i);
      put(a[31:0], a[63:32], a[95:64], a[127:96]);
      if (i == 0) check(upload_slot_o == 1, "R3", "slot after first", upload_slot_o, 1);
    end
    check(upload_slot_o == 0, "R3", "slot wrap", upload_slot_o, 0);

    // R1 R5 R8: walk through the whole program
    cmd(2'd2, 32'd0);
    for (int i = 0; i < 64; i++) begin
      check(pc_o == SW'(i), "R5", "sequential pc", pc_o, i);
      check(instr_o == sig(i), "R1", "stored instruction", instr_o, sig(i));
      check(done_o == (i == 63), "R8", "done flag", done_o, (i == 63));
      if (i < 63) step();
    end
    step();
    check(run_o == 0 && pc_o == 63, "R8", "halt after end", {run_o, pc_o}, {1'b0, 6'd63});

    // R11: reserved command
    cmd(2'd3, 32'h15);
    check(upload_slot_o == 0 && run_o == 0 && pc_o == 63, "R11", "reserved cmd",
          {upload_slot_o, run_o, pc_o}, {6'd0, 1'b0, 6'd63});

    // R2: partial upload discarded
    cmd(2'd0, 32'd10);
    cmd(2'd1, 32'h1111_1111);
    cmd(2'd1, 32'h2222_2222);
    cmd(2'd0, 32'd20);
    check(upload_slot_o == 20, "R2", "reselect slot", upload_slot_o, 20);
    put(32'h0, 32'hDEAD_BEEF, 32'h0, 32'h1);
    check(upload_slot_o == 21, "R3", "slot after commit", upload_slot_o, 21);
    cmd(2'd2, 32'd10);
    check(instr_o == sig(10), "R2", "old slot intact", instr_o, sig(10));
    cmd(2'd2, 32'd20);
    check(instr_o == {32'h1, 32'h0, 32'hDEAD_BEEF, 32'h0}, "R2", "realigned words",
          instr_o, {32'h1, 32'h0, 32'hDEAD_BEEF, 32'h0});
    check(done_o == 1, "R8", "done on end", done_o, 1);

    // R6: jump sweep over conditional bit and condition input
    load_at(40, 0, 0, 0, 1);
    load_at(31, 0, 0, 0, 1);
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 2; p++) begin
        load_at(30, 32'(1 | (c << 2)), 0, 32'h0000_0100 | 32'd40, 0);
        cond_pass = p[0];
        cmd(2'd2, 32'd30);
        check(pc_o == 30, "R4", "entry", pc_o, 30);
        step();
        check(pc_o == ((c == 1 && p == 0) ? 6'd31 : 6'd40), "R6", "jump outcome",
              pc_o, (c == 1 && p == 0) ? 31 : 40);
        check(done_o == 1, "R6", "landed on end", done_o, 1);
      end
    end

    // R6: self loop exits when the condition falls
    load_at(33, 32'd5, 0, 32'd33, 0);
    load_at(34, 0, 0, 0, 1);
    cond_pass = 1'b1;
    cmd(2'd2, 32'd33);
    for (int k = 0; k < 3; k++) begin
      step();
      check(pc_o == 33 && run_o, "R6", "loop holds", pc_o, 33);
    end
    cond_pass = 1'b0;
    step();
    check(pc_o == 34 && done_o, "R6", "loop exit", pc_o, 34);

    // R7: nested call and return
    cond_pass = 1'b1;
    load_at(50, 32'd2, 0, 32'd55, 0);
    load_at(51, 0, 0, 0, 1);
    load_at(55, 32'd2, 0, 32'd58, 0);
    load_at(56, 32'd3, 0, 0, 0);
    load_at(58, 32'd3, 0, 0, 0);
    cmd(2'd2, 32'd50);
    step(); check(pc_o == 55, "R7", "call 1", pc_o, 55);
    step(); check(pc_o == 58, "R7", "call 2", pc_o, 58);
    step(); check(pc_o == 56, "R7", "return 1", pc_o, 56);
    step(); check(pc_o == 51 && done_o, "R7", "return 2", pc_o, 51);
    step(); check(run_o == 0 && err_o == 0, "R7", "clean end", {run_o, err_o}, 0);

    // R9: overflow on fifth nested call
    for (int i = 0; i < 5; i++) load_at(i, 32'd2, 0, 32'(i + 1), 0);
    load_at(5, 0, 0, 0, 1);
    cmd(2'd2, 32'd0);
    for (int i = 1; i < 5; i++) begin
      step(); check(pc_o == SW'(i) && run_o, "R7", "call chain", pc_o, i);
    end
    step();
    check(err_o == 1 && run_o == 0 && pc_o == 4, "R9", "overflow fault",
          {err_o, run_o, pc_o}, {1'b1, 1'b0, 6'd4});

    // R4 R9: run clears fault and stack; failed conditional return is harmless
    load_at(60, 32'd7, 0, 0, 0);
    cond_pass = 1'b0;
    cmd(2'd2, 32'd60);
    check(err_o == 0 && run_o == 1, "R4", "fault cleared", {err_o, run_o}, 2'b01);
    step();
    check(pc_o == 61 && err_o == 0, "R9", "untaken return", {err_o, pc_o}, {1'b0, 6'd61});
    step(); step(); step();
    load_at(60, 32'd3, 0, 0, 0);
    cmd(2'd2, 32'd60);
    step();
    check(err_o == 1 && run_o == 0 && pc_o == 60, "R9", "underflow after stack clear",
          {err_o, run_o, pc_o}, {1'b1, 1'b0, 6'd60});
    cmd(2'd2, 32'd5);
    check(err_o == 0 && run_o == 1 && pc_o == 5, "R4", "restart", {err_o, run_o, pc_o},
          {1'b0, 1'b1, 6'd5});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule